// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD timing controller and its supply rails up and down in one fixed order. It issues byte writes over a write-only register port. Each write carries a 3-bit register address and an 8-bit value, and the block waits for the port to accept each write before it issues the next.

Millisecond guard delays are counted from a one-pulse-per-microsecond tick. Twice in each full sequence the block hands the common-voltage value to an external serial DAC writer and waits for that writer to report completion.

After a cold power-up the block remembers that the panel is live. A later power-up request then only rewrites the phase and resolution registers. A power-down request starts with a two-frame drain, removes the rails in reverse, and clears the live flag. Requests that arrive while a sequence runs are kept and serviced afterwards.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `busy`, `wr_valid`, `dac_start` and `panel_on` are all 0.
- R2: When `panel_on` is 0, a power-up request produces these writes, in this order, as (address, data) pairs:
  - (6,1F), (3,03), (4,00), (4,04)
  - (3,07), (6,09)
  - (3,17), (4,06)
  - (6,01), (3,1F), (4,07), (6,00)
  - (1,phase), (7,00)
  - (0,resolution)

  A DAC hand-off happens between (6,09) and (3,17). `panel_on` is 1 when the sequence ends. The address map is: 0 resolution, 1 phase, 3 power0, 4 power1, 6 interface control, 7 polarity. A power1 write never turns bit0 (VW) on unless bits 1 and 2 are also on.
- R3: The phase value is computed as follows:
  - QVGA (`res_qvga`=1): always 0x13.
  - VGA with `phase_vld`: ((`phase_val` & 0xF) << 1) | 1.
  - VGA without `phase_vld`: 1.

  The resolution value is 1 for QVGA and 0 for VGA. Inputs are sampled when the request is accepted.
- R4: The power-up DAC hand-off presents `dac_code` = `comv_val` when `comv_vld` is set, else 125, with `dac_base` = 0x04. The power-down hand-off presents code 0 with base 0x14. `dac_start` is a one-cycle pulse, and the sequence does not advance until `dac_done` is seen.
- R5: At least 3·`US_PER_MS` ticks pass between the (4,04) write and the next write. At least 2·`US_PER_MS` ticks pass between (4,06) and the next write, and at least 1·`US_PER_MS` between (7,00) and the resolution write.
- R6: When `panel_on` is 1, a power-up request produces only (1,phase) then (0,resolution).
- R7: A power-down request waits at least 34·`US_PER_MS` ticks, then writes:
  - (4,06), (6,08), (3,14)
  - a DAC hand-off
  - (4,04), (3,04), (6,1E), (3,00), (4,00)

  `panel_on` is 0 at the end.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R9: A request arriving while `busy` is high is serviced after the running sequence ends. When both kinds are pending, power-down goes first.
- R10: `busy` rises the cycle after a request is accepted and falls after the last write of the sequence. While `busy` is low, no write or DAC start is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Power-up request |
| down_req | input | 1 | Power-down request |
| res_qvga | input | 1 | 1 selects QVGA, 0 selects VGA |
| phase_val | input | 4 | Phase adjust value |
| phase_vld | input | 1 | `phase_val` is valid |
| comv_val | input | 8 | Common-voltage DAC code |
| comv_vld | input | 1 | `comv_val` is valid |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| wr_valid | output | 1 | Register write request |
| wr_addr | output | 3 | Register address |
| wr_data | output | 8 | Register data |
| wr_ready | input | 1 | Write accepted |
| dac_start | output | 1 | Start the DAC writer |
| dac_base | output | 8 | Power0 bits the DAC writer keeps steady |
| dac_code | output | 8 | DAC code to send |
| dac_done | input | 1 | DAC writer finished |
| busy | output | 1 | A sequence is running |
| panel_on | output | 1 | Panel initialised flag |

## Verification
The hardest case to reach is a request that arrives in the middle of a long sequence. The down-before-up priority is especially hard, because both requests must be pending together when the block returns to idle.

The stimulus first issues a power-down. While that sequence is still in its drain wait, the stimulus pulses a power-up. The bench then checks that the full down list is followed by a complete cold list, not a warm one.

The random phase toggles write acceptance and the microsecond tick on every cycle. It also delays `dac_done`. Together these stall every state of the sequence and exercise the hold rules.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
   typedef enum logic [1:0] {K_WR, K_WAIT, K_DAC, K_END} step_kind_t;

   localparam int STEP_W     = 6;
   localparam int COLD_START = 0;
   localparam int WARM_START = 20;
   localparam int DOWN_START = 23;

   localparam logic [2:0] A_RES  = 3'd0;
   localparam logic [2:0] A_PHS  = 3'd1;
   localparam logic [2:0] A_PWR0 = 3'd3;
   localparam logic [2:0] A_PWR1 = 3'd4;
   localparam logic [2:0] A_CTL  = 3'd6;
   localparam logic [2:0] A_POL  = 3'd7;

   localparam logic [7:0] P1_VW   = 8'h01;
   localparam logic [7:0] P1_GATE = 8'h02;
   localparam logic [7:0] P1_VDD  = 8'h04;

   localparam logic [7:0] P0_CLK  = 8'h01;
   localparam logic [7:0] P0_DAT  = 8'h02;
   localparam logic [7:0] P0_DAC  = 8'h04;
   localparam logic [7:0] P0_COM  = 8'h08;
   localparam logic [7:0] P0_VCC5 = 8'h10;

   localparam logic [7:0] C_INIT  = 8'h01;
   localparam logic [7:0] C_IOFF  = 8'h02;
   localparam logic [7:0] C_PDWN  = 8'h04;
   localparam logic [7:0] C_COMX  = 8'h08;
   localparam logic [7:0] C_DACX  = 8'h10;
endpackage

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
   parameter int US_PER_MS = 1000,
   parameter int MAX_MS    = 34
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [5:0] ms,
   input  logic       us_tick,
   output logic       expired
);
   localparam int CNT_W = $clog2(MAX_MS * US_PER_MS + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= CNT_W'(int'(ms) * US_PER_MS);
      else if (us_tick && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !us_tick && !load) |=> (cnt == $past(cnt))); // R5
   AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (load && ms != '0) |=> !expired); // R5
endmodule

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
   import lcd_seq_pkg::*;
#(
   parameter int T_VDD_MS    = 3,
   parameter int T_GATE_MS   = 2,
   parameter int T_SETTLE_MS = 1,
   parameter int T_DRAIN_MS  = 34
) (
   input  logic [STEP_W-1:0] step,
   input  logic [7:0]        phase_code,
   input  logic [7:0]        res_code,
   input  logic [7:0]        comv_code,
   output step_kind_t        kind,
   output logic [2:0]        addr,
   output logic [7:0]        data,
   output logic [5:0]        wait_ms,
   output logic [7:0]        dac_base,
   output logic [7:0]        dac_code
);
   always_comb begin
      kind     = K_WR;
      addr     = A_CTL;
      data     = 8'h00;
      wait_ms  = 6'd0;
      dac_base = 8'h00;
      dac_code = 8'h00;
      case (int'(step))
         // cold power-up
         0:  begin addr = A_CTL;  data = C_INIT | C_IOFF | C_PDWN | C_COMX | C_DACX; end
         1:  begin addr = A_PWR0; data = P0_CLK | P0_DAT; end
         2:  begin addr = A_PWR1; data = 8'h00; end
         3:  begin addr = A_PWR1; data = P1_VDD; end
         4:  begin kind = K_WAIT; wait_ms = 6'(T_VDD_MS); end
         5:  begin addr = A_PWR0; data = P0_CLK | P0_DAT | P0_DAC; end
         6:  begin addr = A_CTL;  data = C_INIT | C_COMX; end
         7:  begin kind = K_DAC;  dac_base = P0_DAC; dac_code = comv_code; end
         8:  begin addr = A_PWR0; data = P0_CLK | P0_DAT | P0_DAC | P0_VCC5; end
         9:  begin addr = A_PWR1; data = P1_GATE | P1_VDD; end
         10: begin kind = K_WAIT; wait_ms = 6'(T_GATE_MS); end
         11: begin addr = A_CTL;  data = C_INIT; end
         12: begin addr = A_PWR0; data = P0_CLK | P0_DAT | P0_DAC | P0_COM | P0_VCC5; end
         13: begin addr = A_PWR1; data = P1_VW | P1_GATE | P1_VDD; end
         14: begin addr = A_CTL;  data = 8'h00; end
         15: begin addr = A_PHS;  data = phase_code; end
         16: begin addr = A_POL;  data = 8'h00; end
         17: begin kind = K_WAIT; wait_ms = 6'(T_SETTLE_MS); end
         18: begin addr = A_RES;  data = res_code; end
         19: begin kind = K_END;  data = 8'h01; end
         // warm re-init
         20: begin addr = A_PHS;  data = phase_code; end
         21: begin addr = A_RES;  data = res_code; end
         22: begin kind = K_END;  data = 8'h01; end
         // power-down
         23: begin kind = K_WAIT; wait_ms = 6'(T_DRAIN_MS); end
         24: begin addr = A_PWR1; data = P1_GATE | P1_VDD; end
         25: begin addr = A_CTL;  data = C_COMX; end
         26: begin addr = A_PWR0; data = P0_DAC | P0_VCC5; end
         27: begin kind = K_DAC;  dac_base = P0_DAC | P0_VCC5; dac_code = 8'h00; end
         28: begin addr = A_PWR1; data = P1_VDD; end
         29: begin addr = A_PWR0; data = P0_DAC; end
         30: begin addr = A_CTL;  data = C_IOFF | C_PDWN | C_COMX | C_DACX; end
         31: begin addr = A_PWR0; data = 8'h00; end
         32: begin addr = A_PWR1; data = 8'h00; end
         default: begin kind = K_END; data = 8'h00; end
      endcase
   end
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
   import lcd_seq_pkg::*;
#(
   parameter int US_PER_MS   = 1000,
   parameter int T_VDD_MS    = 3,
   parameter int T_GATE_MS   = 2,
   parameter int T_SETTLE_MS = 1,
   parameter int T_DRAIN_MS  = 34,
   parameter int QVGA_PHASE  = 9,
   parameter int DEF_COMV    = 125
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       up_req,
   input  logic       down_req,
   input  logic       res_qvga,
   input  logic [3:0] phase_val,
   input  logic       phase_vld,
   input  logic [7:0] comv_val,
   input  logic       comv_vld,
   input  logic       us_tick,
   output logic       wr_valid,
   output logic [2:0] wr_addr,
   output logic [7:0] wr_data,
   input  logic       wr_ready,
   output logic       dac_start,
   output logic [7:0] dac_base,
   output logic [7:0] dac_code,
   input  logic       dac_done,
   output logic       busy,
   output logic       panel_on
);
   localparam int MAX_MS = (T_DRAIN_MS > T_VDD_MS) ? T_DRAIN_MS : T_VDD_MS;

   if (US_PER_MS < 1) begin : g_bad_tick
      $error("US_PER_MS must be at least 1");
   end
   if (MAX_MS > 63 || T_GATE_MS > 63 || T_SETTLE_MS > 63) begin : g_bad_ms
      $error("delays are limited to 63 ms");
   end
   if (QVGA_PHASE > 15 || DEF_COMV > 255) begin : g_bad_val
      $error("QVGA_PHASE or DEF_COMV out of range");
   end

   typedef enum logic [2:0] {S_IDLE, S_RUN, S_WR, S_WAIT, S_DGO, S_DWAIT} state_t;

   state_t            state;
   logic [STEP_W-1:0] step;
   logic              up_pend, dn_pend;
   logic [7:0]        phase_l, res_l, comv_l;
   step_kind_t        kind;
   logic [5:0]        wait_ms;
   logic              tmr_load, tmr_exp;
   logic              take_dn, take_up;

   lcd_seq_rom #(
      .T_VDD_MS(T_VDD_MS), .T_GATE_MS(T_GATE_MS),
      .T_SETTLE_MS(T_SETTLE_MS), .T_DRAIN_MS(T_DRAIN_MS)
   ) u_rom (
      .step(step), .phase_code(phase_l), .res_code(res_l), .comv_code(comv_l),
      .kind(kind), .addr(wr_addr), .data(wr_data), .wait_ms(wait_ms),
      .dac_base(dac_base), .dac_code(dac_code)
   );

   lcd_seq_timer #(.US_PER_MS(US_PER_MS), .MAX_MS(MAX_MS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .ms(wait_ms),
      .us_tick(us_tick), .expired(tmr_exp)
   );

   assign take_dn  = (state == S_IDLE) && (dn_pend || down_req);
   assign take_up  = (state == S_IDLE) && !take_dn && (up_pend || up_req);
   assign tmr_load = (state == S_RUN) && (kind == K_WAIT);
   assign wr_valid = (state == S_WR);
   assign dac_start = (state == S_DGO);
   assign busy     = (state != S_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         step     <= '0;
         up_pend  <= 1'b0;
         dn_pend  <= 1'b0;
         panel_on <= 1'b0;
         phase_l  <= 8'h00;
         res_l    <= 8'h00;
         comv_l   <= 8'h00;
      end else begin
         dn_pend <= take_dn ? 1'b0 : (dn_pend | down_req);
         up_pend <= take_up ? 1'b0 : (up_pend | up_req);
         case (state)
            S_IDLE: begin
               if (take_dn) begin
                  step  <= STEP_W'(DOWN_START);
                  state <= S_RUN;
               end else if (take_up) begin
                  step    <= panel_on ? STEP_W'(WARM_START) : STEP_W'(COLD_START);
                  res_l   <= {7'd0, res_qvga};
                  phase_l <= res_qvga  ? 8'(QVGA_PHASE * 2 + 1)
                           : phase_vld ? {3'd0, phase_val, 1'b1} : 8'h01;
                  comv_l  <= comv_vld ? comv_val : 8'(DEF_COMV);
                  state   <= S_RUN;
               end
            end
            S_RUN: begin
               case (kind)
                  K_WR:   state <= S_WR;
                  K_WAIT: state <= S_WAIT;
                  K_DAC:  state <= S_DGO;
                  default: begin
                     panel_on <= wr_data[0];
                     state    <= S_IDLE;
                  end
               endcase
            end
            S_WR: if (wr_ready) begin
               step  <= step + 1'b1;
               state <= S_RUN;
            end
            S_WAIT: if (tmr_exp) begin
               step  <= step + 1'b1;
               state <= S_RUN;
            end
            S_DGO: state <= S_DWAIT;
            S_DWAIT: if (dac_done) begin
               step  <= step + 1'b1;
               state <= S_RUN;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!wr_valid && !dac_start)); // R10
   AST_DAC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dac_start |=> !dac_start); // R4
   AST_VW_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr == A_PWR1 && wr_data[0]) |-> (wr_data[2:1] == 2'b11)); // R2
   AST_DN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (dn_pend || down_req)) |=> (busy && !panel_on == !$past(panel_on))); // R9
endmodule

// File: tb/lcd_pwr_seq_test.sv
`timescale 1ns/1ps
module lcd_pwr_seq_test;
   localparam int USPM = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up_req = 0, down_req = 0, res_qvga = 0, phase_vld = 0, comv_vld = 0;
   logic [3:0] phase_val = 0;
   logic [7:0] comv_val = 0;
   logic us_tick = 0, wr_ready = 0, dac_done = 0;
   logic wr_valid, dac_start, busy, panel_on;
   logic [2:0] wr_addr;
   logic [7:0] wr_data, dac_base, dac_code;

   always #10 clk = ~clk;

   lcd_pwr_seq #(.US_PER_MS(USPM)) uut (
      .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
      .res_qvga(res_qvga), .phase_val(phase_val), .phase_vld(phase_vld),
      .comv_val(comv_val), .comv_vld(comv_vld), .us_tick(us_tick),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .dac_start(dac_start), .dac_base(dac_base), .dac_code(dac_code),
      .dac_done(dac_done), .busy(busy), .panel_on(panel_on)
   );

   int tests = 0, fails = 0;
   int tick_cnt = 0, cycles = 0;
   int wn = 0, dn = 0, en = 0;
   logic [10:0] wlog [0:127];
   int          wstamp [0:127];
   logic [15:0] dlog [0:7];
   logic [10:0] elog [0:127];
   int dac_cd = 0;
   logic busy_q = 0;
   int busy_stamp = 0;
   bit model_on = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // port-side environment driven away from the active edge
   always @(negedge clk) begin
      cycles++;
      us_tick  = ($urandom % 3) == 0;
      if (us_tick) tick_cnt++;
      wr_ready = ($urandom % 4) != 0;
      if (wr_valid && wr_ready && wn < 128) begin
         wlog[wn] = {wr_addr, wr_data};
         wstamp[wn] = tick_cnt;
         wn++;
      end
      dac_done = 1'b0;
      if (dac_cd > 0) begin
         dac_cd--;
         if (dac_cd == 0) dac_done = 1'b1;
      end
      if (dac_start) begin
         if (dn < 8) dlog[dn] = {dac_base, dac_code};
         dn++;
         dac_cd = 1 + ($urandom % 5);
      end
      if (busy && !busy_q) busy_stamp = tick_cnt;
      busy_q = busy;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   function automatic logic [7:0] phase_exp(bit q, bit v, logic [3:0] p);
      if (q) return 8'h13;
      if (v) return {3'd0, p, 1'b1};
      return 8'h01;
   endfunction

   task automatic ex(input logic [2:0] a, input logic [7:0] d);
      elog[en] = {a, d};
      en++;
   endtask

   task automatic exp_cold(input logic [7:0] ph, input bit q);
      ex(6,8'h1F); ex(3,8'h03); ex(4,8'h00); ex(4,8'h04); ex(3,8'h07); ex(6,8'h09);
      ex(3,8'h17); ex(4,8'h06); ex(6,8'h01); ex(3,8'h1F); ex(4,8'h07); ex(6,8'h00);
      ex(1,ph); ex(7,8'h00); ex(0,{7'd0,q});
   endtask

   task automatic exp_down();
      ex(4,8'h06); ex(6,8'h08); ex(3,8'h14); ex(4,8'h04);
      ex(3,8'h04); ex(6,8'h1E); ex(3,8'h00); ex(4,8'h00);
   endtask

   task automatic clear_logs();
      wn = 0; dn = 0; en = 0;
   endtask

   task automatic compare(input string req);
      int bad = -1;
      check(wn == en, req, wn, en);
      for (int i = 0; i < en && i < wn; i++)
         if (bad < 0 && wlog[i] !== elog[i]) bad = i;
      if (bad >= 0) check(0, req, int'(wlog[bad]), int'(elog[bad]));
      else check(1, req, 0, 0);
   endtask

   task automatic pulse(input bit down);
      @(negedge clk);
      if (down) down_req = 1; else up_req = 1;
      @(negedge clk);
      down_req = 0; up_req = 0;
   endtask

   task automatic wait_idle();
      while (busy || busy_q !== 1'b0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic do_up(input bit q, input bit pv, input logic [3:0] p,
                        input bit cv, input logic [7:0] c, input string req);
      logic [7:0] ph;
      bit cold;
      res_qvga = q; phase_vld = pv; phase_val = p; comv_vld = cv; comv_val = c;
      ph = phase_exp(q, pv, p);
      cold = !model_on;
      clear_logs();
      if (cold) exp_cold(ph, q);
      else begin ex(1, ph); ex(0, {7'd0, q}); end
      pulse(0);
      wait_idle();
      compare(req);
      check(panel_on == 1'b1, "R2 panel_on after up", panel_on, 1);
      if (cold) begin
         check(dn == 1 && dlog[0] == {8'h04, (cv ? c : 8'd125)}, "R4 up dac",
               int'(dlog[0]), int'({8'h04, (cv ? c : 8'd125)}));
         check(wstamp[4] - wstamp[3] >= 3*USPM, "R5 vdd wait", wstamp[4]-wstamp[3], 3*USPM);
         check(wstamp[8] - wstamp[7] >= 2*USPM, "R5 gate wait", wstamp[8]-wstamp[7], 2*USPM);
         check(wstamp[14] - wstamp[13] >= USPM, "R5 settle wait", wstamp[14]-wstamp[13], USPM);
      end else begin
         check(dn == 0, "R6 warm no dac", dn, 0);
      end
      model_on = 1;
   endtask

   task automatic do_down(input string req);
      clear_logs();
      exp_down();
      pulse(1);
      wait_idle();
      compare(req);
      check(panel_on == 1'b0, "R7 panel_on after down", panel_on, 0);
      check(dn == 1 && dlog[0] == 16'h1400, "R4 down dac", int'(dlog[0]), 16'h1400);
      check(wstamp[0] - busy_stamp >= 34*USPM, "R7 drain wait", wstamp[0]-busy_stamp, 34*USPM);
      model_on = 0;
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(!busy && !wr_valid && !dac_start && !panel_on, "R1 reset",
            {busy, wr_valid, dac_start, panel_on}, 0);
      rst_n = 1;
      @(negedge clk);
      check(!busy && !wr_valid && !panel_on, "R1 after release", {busy, wr_valid, panel_on}, 0);

      do_up(0, 1, 4'hA, 1, 8'h55, "R2 R3 cold VGA");
      do_up(1, 1, 4'h3, 1, 8'h10, "R6 R3 warm QVGA");
      do_up(0, 0, 4'h7, 0, 8'h00, "R6 R3 warm VGA no phase");
      do_down("R7 down");
      do_up(1, 0, 4'h0, 0, 8'h99, "R2 R3 cold QVGA default comv");

      // R9: power-up requested during the drain of a power-down
      res_qvga = 0; phase_vld = 1; phase_val = 4'h5; comv_vld = 1; comv_val = 8'h22;
      clear_logs();
      exp_down();
      exp_cold(8'h0B, 0);
      pulse(1);
      repeat (5) @(negedge clk);
      check(busy == 1'b1, "R10 busy during down", busy, 1);
      pulse(0);
      while (!(panel_on && !busy)) @(negedge clk);
      repeat (2) @(negedge clk);
      compare("R9 pending up after down");
      check(dn == 2 && dlog[1] == 16'h0422, "R9 cold dac after down", int'(dlog[1]), 16'h0422);
      model_on = 1;

      // random mix
      for (int k = 0; k < 6; k++) begin
         if (($urandom % 3) == 0) do_down("R7 random down");
         else do_up($urandom % 2, $urandom % 2, 4'($urandom), $urandom % 2,
                    8'($urandom), "R3 random up");
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule